// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block is the control logic on the device side of an asynchronous DRAM with four data pins. A fast local clock oversamples the row strobe, column strobe, write enable and output enable. All four are active low. The block then works out what the memory controller on the other side of those pins is asking for. It classifies every falling edge of the row strobe as one of three cycles:

- a normal row activation;
- a refresh, which happens when the column strobe was already low;
- a refresh that also switches the part into compressed parallel test mode, which happens when write enable was low as well.

Refresh rows come from an internal counter. The block keeps a test-mode flag. Each column access is reported as a read, an early write or a delayed write. The block drives the enable for the data output buffers.

The array, the sense logic and the analog timing limits are not part of this block. The outputs are single-cycle event pulses with their row, column and kind attached, plus two level outputs: the test-mode flag and the data-output enable. The array controller acts on the pulses, and the pad ring uses the level outputs. A row-strobe rise that ends a row cycle with no column access is reported as a row-only refresh.

Top module: `strobe_cycle_decoder`

## Requirements
- R1: After reset every event pulse is low, `dq_oe` and `test_mode` are low, and the refresh counter holds row 0.
- R2: A row-strobe fall with the column strobe high produces one `act_stb` pulse, and `act_row` equals the row address present at that fall.
- R3: A row-strobe fall with the column strobe low and write enable high produces one `rfsh_stb` pulse with `rfsh_test` = 0. `rfsh_row` is the refresh counter value and the external address is ignored. This refresh clears `test_mode`.
- R4: The refresh counter advances by one after every refresh pulse, of either kind. It wraps from 2^ROW_W-1 back to 0.
- R5: A row-strobe fall with both the column strobe and write enable low produces `rfsh_stb` with `rfsh_test` = 1 and sets `test_mode`. Ordinary read cycles leave `test_mode` set.
- R6: A row cycle that was opened normally and then ends with a row-strobe rise, with no column-strobe fall in between, produces one `ronly_stb` pulse and clears `test_mode`.
- R7: In an open row, a column-strobe fall with write enable high produces `acc_stb` with `acc_kind` = 0 (read) and `acc_col` equal to the column address. `dq_oe` then rises if output enable is low.
- R8: In an open row, a column-strobe fall with write enable low produces `acc_stb` with `acc_kind` = 1 (early write). `dq_oe` stays low for the rest of that access, even when output enable is low.
- R9: A write-enable fall while the column strobe is low, after a read in the same column access, produces `acc_stb` with `acc_kind` = 2 (delayed write) and drives `dq_oe` low.
- R10: After a read, `dq_oe` stays high while the column strobe is high and the row strobe is low (extended data out). It also stays high while the row strobe is high and the column strobe is low, including across a refresh hidden under a held column strobe. It falls only once both strobes are high.
- R11: Output enable high holds `dq_oe` low. Output enable low again restores it if read data is still held.
- R12: While `test_mode` is set, bits 1:0 of `acc_col` are reported as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Multiplexed row/column address |
| act_stb | output | 1 | Row activation pulse |
| act_row | output | ROW_W | Row opened by the activation |
| rfsh_stb | output | 1 | Refresh pulse |
| rfsh_row | output | ROW_W | Row refreshed, taken from the counter |
| rfsh_test | output | 1 | Refresh was the test-mode entry kind |
| ronly_stb | output | 1 | Row-only refresh detected at the row-strobe rise |
| test_mode | output | 1 | Parallel test mode flag |
| acc_stb | output | 1 | Column access pulse |
| acc_kind | output | 2 | 0 read, 1 early write, 2 delayed write |
| acc_col | output | COL_W | Column address of the access |
| dq_oe | output | 1 | Data output buffer enable |

## Verification
A wrong refresh counter shows at `rfsh_row` on the very next refresh. So the bench runs a full wrap of hidden refreshes and checks every row number. A stale classification or a stale test-mode flag shows in the kind of the next event, or in the masked column bits, as soon as the next row or column strobe falls. A data-enable latch that is wrong shows on `dq_oe` within a few clocks of the strobe change that should have moved it. Those cases are EDO hold, hidden refresh, early write and the delayed-write cut-off.

// File: rtl/scd_pkg.sv
package scd_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_EARLY = 2'd1,
    ACC_LATE  = 2'd2
  } acc_kind_t;

  typedef enum logic [1:0] {
    ROW_IDLE = 2'd0,
    ROW_OPEN = 2'd1,
    ROW_RFSH = 2'd2
  } row_state_t;

endpackage

// File: rtl/scd_sync.sv
// Multi-stage level synchronizer; the number of stages is a parameter.
module scd_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [W-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= g_stg[s-1].q;
      end
    end
  end

  assign lvl = g_stg[STAGES-1].q;

endmodule

// File: rtl/scd_refresh_ctr.sv
// Internal refresh row counter, wrapping modulo 2**ROW_W.
module scd_refresh_ctr #(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [ROW_W-1:0] cnt
);

  localparam logic [ROW_W-1:0] ONE = ROW_W'(1);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (adv) cnt <= cnt + ONE;
  end

endmodule

// File: rtl/scd_row_fsm.sv
// Row-strobe cycle classifier: activation, refresh, test-mode entry, row-only refresh.
module scd_row_fsm
  import scd_pkg::*;
#(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ras_fall,
  input  logic             ras_rise,
  input  logic             cas_fall,
  input  logic             cas_lvl,
  input  logic             we_lvl,
  input  logic [ROW_W-1:0] row_addr,
  input  logic [ROW_W-1:0] cnt,
  output logic             act_stb,
  output logic [ROW_W-1:0] act_row,
  output logic             rfsh_stb,
  output logic [ROW_W-1:0] rfsh_row,
  output logic             rfsh_test,
  output logic             ronly_stb,
  output logic             test_mode,
  output logic             row_open
);

  row_state_t state;
  logic       col_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ROW_IDLE;
      col_seen  <= 1'b0;
      act_stb   <= 1'b0;
      act_row   <= '0;
      rfsh_stb  <= 1'b0;
      rfsh_row  <= '0;
      rfsh_test <= 1'b0;
      ronly_stb <= 1'b0;
      test_mode <= 1'b0;
    end else begin
      act_stb   <= 1'b0;
      rfsh_stb  <= 1'b0;
      ronly_stb <= 1'b0;
      unique case (state)
        ROW_IDLE: begin
          if (ras_fall) begin
            if (!cas_lvl) begin
              // column strobe first: refresh from the counter, address ignored
              rfsh_stb  <= 1'b1;
              rfsh_row  <= cnt;
              rfsh_test <= !we_lvl;
              test_mode <= !we_lvl;
              state     <= ROW_RFSH;
            end else begin
              act_stb  <= 1'b1;
              act_row  <= row_addr;
              col_seen <= 1'b0;
              state    <= ROW_OPEN;
            end
          end
        end
        ROW_OPEN: begin
          if (cas_fall) col_seen <= 1'b1;
          if (ras_rise) begin
            state <= ROW_IDLE;
            if (!col_seen && !cas_fall) begin
              ronly_stb <= 1'b1;
              test_mode <= 1'b0;
            end
          end
        end
        ROW_RFSH: begin
          if (ras_rise) state <= ROW_IDLE;
        end
        default: state <= ROW_IDLE;
      endcase
    end
  end

  assign row_open = (state == ROW_OPEN);

endmodule

// File: rtl/scd_col_ctl.sv
// Column access classifier and data-output enable with extended data out hold.
module scd_col_ctl
  import scd_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             row_open,
  input  logic             test_mode,
  input  logic             cas_fall,
  input  logic             cas_lvl,
  input  logic             ras_lvl,
  input  logic             we_fall,
  input  logic             we_lvl,
  input  logic             oe_lvl,
  input  logic [COL_W-1:0] col_addr,
  output logic             acc_stb,
  output logic [1:0]       acc_kind,
  output logic [COL_W-1:0] acc_col,
  output logic             dq_oe
);

  localparam int MASK_W = (COL_W < 2) ? COL_W : 2;

  logic             drv, drv_nx;
  logic             rd_open;
  logic             do_read, do_early, do_late;
  logic [COL_W-1:0] col_eff;

  assign do_read  = row_open && cas_fall && we_lvl;
  assign do_early = row_open && cas_fall && !we_lvl;
  assign do_late  = row_open && we_fall && !cas_lvl && !cas_fall && rd_open;

  // compressed test mode: the two low column bits are don't-care
  always_comb begin
    col_eff = col_addr;
    if (test_mode) col_eff[MASK_W-1:0] = '0;
  end

  always_comb begin
    drv_nx = drv;
    if (ras_lvl && cas_lvl)   drv_nx = 1'b0;
    if (do_read)              drv_nx = 1'b1;
    if (do_early || do_late)  drv_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv      <= 1'b0;
      rd_open  <= 1'b0;
      dq_oe    <= 1'b0;
      acc_stb  <= 1'b0;
      acc_kind <= ACC_READ;
      acc_col  <= '0;
    end else begin
      drv     <= drv_nx;
      dq_oe   <= drv_nx && !oe_lvl;
      acc_stb <= 1'b0;
      if (cas_lvl) rd_open <= 1'b0;
      if (do_read) begin
        acc_stb  <= 1'b1;
        acc_kind <= ACC_READ;
        acc_col  <= col_eff;
        rd_open  <= 1'b1;
      end else if (do_early) begin
        acc_stb  <= 1'b1;
        acc_kind <= ACC_EARLY;
        acc_col  <= col_eff;
        rd_open  <= 1'b0;
      end else if (do_late) begin
        acc_stb  <= 1'b1;
        acc_kind <= ACC_LATE;
        rd_open  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/strobe_cycle_decoder.sv
module strobe_cycle_decoder #(
  parameter int ROW_W       = 12,
  parameter int COL_W       = 10,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              act_stb,
  output logic [ROW_W-1:0]  act_row,
  output logic              rfsh_stb,
  output logic [ROW_W-1:0]  rfsh_row,
  output logic              rfsh_test,
  output logic              ronly_stb,
  output logic              test_mode,
  output logic              acc_stb,
  output logic [1:0]        acc_kind,
  output logic [COL_W-1:0]  acc_col,
  output logic              dq_oe
);

  // strobe bit order: [0] row, [1] column, [2] write, [3] output
  logic [3:0]        stb_lvl, stb_prev;
  logic [ADDR_W-1:0] addr_lvl;
  logic              ras_lvl, cas_lvl, we_lvl, oe_lvl;
  logic              ras_fall, ras_rise, cas_fall, we_fall;
  logic [ROW_W-1:0]  rfsh_cnt;
  logic              row_open;

  scd_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) u_stb_sync (
    .clk (clk), .rst (rst),
    .din ({oe_n, we_n, cas_n, ras_n}),
    .lvl (stb_lvl)
  );

  scd_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_addr_sync (
    .clk (clk), .rst (rst),
    .din (addr),
    .lvl (addr_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) stb_prev <= 4'hF;
    else     stb_prev <= stb_lvl;
  end

  assign ras_lvl  = stb_lvl[0];
  assign cas_lvl  = stb_lvl[1];
  assign we_lvl   = stb_lvl[2];
  assign oe_lvl   = stb_lvl[3];
  assign ras_fall = stb_prev[0] && !stb_lvl[0];
  assign ras_rise = !stb_prev[0] && stb_lvl[0];
  assign cas_fall = stb_prev[1] && !stb_lvl[1];
  assign we_fall  = stb_prev[2] && !stb_lvl[2];

  scd_refresh_ctr #(.ROW_W(ROW_W)) u_ctr (
    .clk (clk), .rst (rst),
    .adv (rfsh_stb),
    .cnt (rfsh_cnt)
  );

  scd_row_fsm #(.ROW_W(ROW_W)) u_row (
    .clk       (clk),
    .rst       (rst),
    .ras_fall  (ras_fall),
    .ras_rise  (ras_rise),
    .cas_fall  (cas_fall),
    .cas_lvl   (cas_lvl),
    .we_lvl    (we_lvl),
    .row_addr  (addr_lvl[ROW_W-1:0]),
    .cnt       (rfsh_cnt),
    .act_stb   (act_stb),
    .act_row   (act_row),
    .rfsh_stb  (rfsh_stb),
    .rfsh_row  (rfsh_row),
    .rfsh_test (rfsh_test),
    .ronly_stb (ronly_stb),
    .test_mode (test_mode),
    .row_open  (row_open)
  );

  scd_col_ctl #(.COL_W(COL_W)) u_col (
    .clk       (clk),
    .rst       (rst),
    .row_open  (row_open),
    .test_mode (test_mode),
    .cas_fall  (cas_fall),
    .cas_lvl   (cas_lvl),
    .ras_lvl   (ras_lvl),
    .we_fall   (we_fall),
    .we_lvl    (we_lvl),
    .oe_lvl    (oe_lvl),
    .col_addr  (addr_lvl[COL_W-1:0]),
    .acc_stb   (acc_stb),
    .acc_kind  (acc_kind),
    .acc_col   (acc_col),
    .dq_oe     (dq_oe)
  );

endmodule

// File: rtl/scd_checker.sv
module scd_checker #(
  parameter int ROW_W = 12,
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             act_stb,
  input logic             rfsh_stb,
  input logic             rfsh_test,
  input logic             ronly_stb,
  input logic             test_mode,
  input logic             acc_stb,
  input logic [1:0]       acc_kind,
  input logic [COL_W-1:0] acc_col,
  input logic             dq_oe,
  input logic             ras_lvl,
  input logic             cas_lvl,
  input logic [ROW_W-1:0] rfsh_cnt
);

  p_one_row_event_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({act_stb, rfsh_stb, ronly_stb}));

  p_cnt_advance_r4: assert property (@(posedge clk) disable iff (rst)
    rfsh_stb |=> rfsh_cnt == ROW_W'($past(rfsh_cnt) + ROW_W'(1)));

  p_test_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (rfsh_stb && rfsh_test) |-> test_mode);

  p_test_exit_r6: assert property (@(posedge clk) disable iff (rst)
    ronly_stb |-> !test_mode);

  p_early_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_stb && acc_kind == 2'd1) |-> !dq_oe);

  p_late_cut_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_stb && acc_kind == 2'd2) |-> !dq_oe);

  p_release_r10: assert property (@(posedge clk) disable iff (rst)
    (ras_lvl && cas_lvl) |=> !dq_oe);

  p_test_col_r12: assert property (@(posedge clk) disable iff (rst)
    (acc_stb && test_mode) |-> acc_col[1:0] == 2'b00);

endmodule

bind strobe_cycle_decoder scd_checker #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .act_stb   (act_stb),
  .rfsh_stb  (rfsh_stb),
  .rfsh_test (rfsh_test),
  .ronly_stb (ronly_stb),
  .test_mode (test_mode),
  .acc_stb   (acc_stb),
  .acc_kind  (acc_kind),
  .acc_col   (acc_col),
  .dq_oe     (dq_oe),
  .ras_lvl   (ras_lvl),
  .cas_lvl   (cas_lvl),
  .rfsh_cnt  (rfsh_cnt)
);

// File: tb/sim_strobe_cycle_decoder.sv
`timescale 1ns/1ps
module sim_strobe_cycle_decoder;

  localparam int ROW_W = 12;
  localparam int COL_W = 10;
  localparam int ROWS  = 1 << ROW_W;
  localparam int GAP   = 5;

  // event types
  localparam int EV_ACT = 0, EV_RFSH = 1, EV_RONLY = 2, EV_ACC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [11:0] addr = '0;
  logic act_stb, rfsh_stb, rfsh_test, ronly_stb, test_mode, acc_stb, dq_oe;
  logic [ROW_W-1:0] act_row, rfsh_row;
  logic [1:0] acc_kind;
  logic [COL_W-1:0] acc_col;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  strobe_cycle_decoder #(.ROW_W(ROW_W), .COL_W(COL_W)) u0 (
    .clk, .rst, .ras_n, .cas_n, .we_n, .oe_n, .addr,
    .act_stb, .act_row, .rfsh_stb, .rfsh_row, .rfsh_test, .ronly_stb,
    .test_mode, .acc_stb, .acc_kind, .acc_col, .dq_oe
  );

  typedef struct { int et; int val; int kind; string req; } ev_t;
  ev_t q[$];

  task automatic expect_ev(input int et, input int val, input int kind, input string req);
    ev_t e;
    e.et = et; e.val = val; e.kind = kind; e.req = req;
    q.push_back(e);
  endtask

  task automatic got(input int et, input int val, input int kind);
    ev_t e;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL R2,R6 unexpected event: actual type %0d val %0h kind %0d, expected none", et, val, kind);
    end else begin
      e = q.pop_front();
      if (e.et != et || e.val != val || e.kind != kind) begin
        errors++;
        $display("FAIL %s: actual type %0d val %0h kind %0d, expected type %0d val %0h kind %0d",
                 e.req, et, val, kind, e.et, e.val, e.kind);
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (act_stb)   got(EV_ACT, int'(act_row), 0);
      if (rfsh_stb)  got(EV_RFSH, int'(rfsh_row), int'(rfsh_test));
      if (ronly_stb) got(EV_RONLY, 0, 0);
      if (acc_stb)   got(EV_ACC, int'(acc_col), int'(acc_kind));
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    repeat (GAP) @(negedge clk);
  endtask

  task automatic set_ras(input logic v); ras_n = v; step(); endtask
  task automatic set_cas(input logic v); cas_n = v; step(); endtask
  task automatic set_we(input logic v);  we_n  = v; step(); endtask
  task automatic set_oe(input logic v);  oe_n  = v; step(); endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 act_stb", int'(act_stb), 0);
    chk("R1 rfsh_stb", int'(rfsh_stb), 0);
    chk("R1 acc_stb", int'(acc_stb), 0);
    chk("R1 dq_oe", int'(dq_oe), 0);
    chk("R1 test_mode", int'(test_mode), 0);

    // R2 activation, R7 read, R10 EDO hold, R11 output enable, R9 delayed write
    addr = 12'h5A3; expect_ev(EV_ACT, 'h5A3, 0, "R2");
    set_ras(1'b0);
    oe_n = 1'b0;
    addr = 12'h1F7; expect_ev(EV_ACC, 'h1F7, 0, "R7");
    set_cas(1'b0);
    chk("R7 dq_oe after read", int'(dq_oe), 1);
    set_cas(1'b1);
    chk("R10 EDO hold with column strobe high", int'(dq_oe), 1);
    addr = 12'h02A; expect_ev(EV_ACC, 'h02A, 0, "R7");
    set_cas(1'b0);
    set_oe(1'b1);
    chk("R11 output enable high", int'(dq_oe), 0);
    set_oe(1'b0);
    chk("R11 output enable low again", int'(dq_oe), 1);
    expect_ev(EV_ACC, 'h02A, 2, "R9");
    set_we(1'b0);
    chk("R9 delayed write cuts output", int'(dq_oe), 0);
    set_we(1'b1);
    set_cas(1'b1);
    set_ras(1'b1);
    chk("R9 output stays off", int'(dq_oe), 0);

    // R8 early write
    addr = 12'h123; expect_ev(EV_ACT, 'h123, 0, "R2");
    set_ras(1'b0);
    we_n = 1'b0;
    addr = 12'h055; expect_ev(EV_ACC, 'h055, 1, "R8");
    set_cas(1'b0);
    chk("R8 early write output off", int'(dq_oe), 0);
    set_cas(1'b1);
    chk("R8 early write output off after column strobe", int'(dq_oe), 0);
    set_we(1'b1);
    set_ras(1'b1);

    // R10 later strobe release and hidden refresh, R3 address ignored
    addr = 12'h200; expect_ev(EV_ACT, 'h200, 0, "R2");
    set_ras(1'b0);
    addr = 12'h0F0; expect_ev(EV_ACC, 'h0F0, 0, "R7");
    set_cas(1'b0);
    set_ras(1'b1);
    chk("R10 hold with row strobe high", int'(dq_oe), 1);
    addr = 12'hFFF; expect_ev(EV_RFSH, exp_cnt, 0, "R3"); exp_cnt++;
    set_ras(1'b0);
    chk("R10 hold across hidden refresh", int'(dq_oe), 1);
    set_ras(1'b1);
    set_cas(1'b1);
    chk("R10 release after both strobes high", int'(dq_oe), 0);

    // R6 row-only refresh
    addr = 12'h0AB; expect_ev(EV_ACT, 'h0AB, 0, "R2");
    set_ras(1'b0);
    expect_ev(EV_RONLY, 0, 0, "R6");
    set_ras(1'b1);

    // R5 test mode entry
    cas_n = 1'b0; we_n = 1'b0; step();
    expect_ev(EV_RFSH, exp_cnt, 1, "R5"); exp_cnt++;
    set_ras(1'b0);
    chk("R5 test mode set", int'(test_mode), 1);
    set_ras(1'b1);
    set_cas(1'b1);
    set_we(1'b1);
    // R12 column masking; read keeps test mode (R5)
    addr = 12'h010; expect_ev(EV_ACT, 'h010, 0, "R2");
    set_ras(1'b0);
    addr = 12'h3FF; expect_ev(EV_ACC, 'h3FC, 0, "R12");
    set_cas(1'b0);
    set_cas(1'b1);
    set_ras(1'b1);
    chk("R5 read keeps test mode", int'(test_mode), 1);
    // R6 exit by row-only refresh
    addr = 12'h011; expect_ev(EV_ACT, 'h011, 0, "R2");
    set_ras(1'b0);
    expect_ev(EV_RONLY, 0, 0, "R6");
    set_ras(1'b1);
    chk("R6 row-only refresh exits test mode", int'(test_mode), 0);
    // R3 exit by normal refresh
    cas_n = 1'b0; we_n = 1'b0; step();
    expect_ev(EV_RFSH, exp_cnt, 1, "R5"); exp_cnt++;
    set_ras(1'b0);
    set_ras(1'b1);
    set_we(1'b1);
    chk("R5 re-entry", int'(test_mode), 1);
    expect_ev(EV_RFSH, exp_cnt, 0, "R3"); exp_cnt++;
    set_ras(1'b0);
    chk("R3 refresh exits test mode", int'(test_mode), 0);
    set_ras(1'b1);

    // R4 counter over a full wrap (column strobe held low)
    for (int i = 0; i <= ROWS; i++) begin
      expect_ev(EV_RFSH, exp_cnt, 0, "R4");
      exp_cnt = (exp_cnt + 1) % ROWS;
      set_ras(1'b0);
      set_ras(1'b1);
    end
    set_cas(1'b1);
    step();
    chk("R4 scoreboard drained", q.size(), 0);
    finish_run();
  end

endmodule